// File: doc/BRIEF.md
# UART Register Bank with Watermark Interrupts

This block is the software-facing side of a serial port. A 32-bit register interface sits on a simple valid/write/address bus. Behind it are two byte queues of eight entries each. One holds bytes waiting for the transmitter. The other holds bytes delivered by the receiver. The block exports the line configuration that the serializer and baud generator need: the enables, the stop-bit count, the clock divisor and the parity mode. It does not serialize bits or generate the baud rate itself.

Three interrupt sources are tracked:

- A transmit low-water condition.
- A receive high-water condition.
- A sticky parity-error event reported by the receiver.

Each source is masked by an enable bit, and all enabled sources are ORed onto one interrupt line. Software clears the parity event by writing a one-shot clear register. That register drops back to zero by itself one cycle after the write.

Top module: `uart_regbank`

## Requirements
- R1: A write to the transmit-data word (offset 0x00) queues bits 7:0 unless the transmit queue already holds 8 bytes, in which case the write is dropped. While transmit is enabled, queued bytes appear oldest first on `tx_data` with `tx_valid` high, and one byte leaves per cycle in which `tx_ready` is high.
- R2: A read of offset 0x00 returns the transmit-queue-full flag in bit 31 and zero in every other bit.
- R3: A read of offset 0x04 returns the oldest received byte in bits 7:0 and the receive-queue-empty flag in bit 31. All other bits read as zero, and bits 7:0 also read as zero when the queue is empty. The read removes the byte only when the queue is not empty. Writes to this offset have no effect.
- R4: A byte offered with `rx_valid` is queued only when receive is enabled and fewer than 8 bytes are held. Otherwise it is dropped.
- R5: Transmit control (0x08) holds enable in bit 0, two-stop-bit select in bit 1 and the transmit threshold in bits 18:16. Receive control (0x0C) holds enable in bit 0 and the receive threshold in bits 18:16. These fields drive the `cfg_*` outputs, and all other bits read as zero.
- R6: Pending bit 0 (offset 0x14) is 1 exactly while the transmit queue holds strictly fewer bytes than the transmit threshold.
- R7: Pending bit 1 is 1 exactly while the receive queue holds strictly more bytes than the receive threshold.
- R8: A one-cycle pulse on `rx_parity_err` sets pending bit 3, which stays set until cleared. Pending bit 2 and bits 31:4 read as zero, and writes to the pending word are ignored. The enable word (0x10) keeps only bits 0, 1 and 3.
- R9: A write to the clear word (0x18) keeps bits 0, 1 and 3 of the data. For the one following cycle the clear word reads back that value, and then it returns to zero. If bit 3 was written, the parity pending bit is cleared at the end of that cycle, unless a new parity pulse arrives in that same cycle. In that case the bit stays set.
- R10: `irq` is 1 exactly when some pending bit and its enable bit are both 1.
- R11: The divisor word (0x1C) keeps bits 15:0 and the line word (0x20) keeps the parity mode in bits 5:3. Both drive their `cfg_*` outputs, and all other bits read as zero. After reset every register, both queues and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit byte available and transmit enabled |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_data | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | Receiver delivers `rx_data` |
| rx_parity_err | input | 1 | Receiver saw a parity mismatch |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_two_stop | output | 1 | Two stop bits selected |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_divisor | output | 16 | Baud divisor |
| cfg_parity | output | 3 | Parity mode |
| irq | output | 1 | Combined interrupt |

## Verification
The delicate coincidence is a fresh parity pulse landing in the very cycle in which a pending one-shot clear is being applied. The bench writes the clear word and then raises `rx_parity_err` for exactly the next cycle. It expects the pending bit still to be set afterwards, while the clear word has already returned to zero. A second case checks a clear with no competing pulse, which must leave the bit at zero. The watermark bits are swept over every threshold and every fill level from empty to full.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
   localparam int BUS_W = 32;

   typedef enum logic [3:0] {
      RB_TXDATA = 4'd0,
      RB_RXDATA = 4'd1,
      RB_TXCTRL = 4'd2,
      RB_RXCTRL = 4'd3,
      RB_IE     = 4'd4,
      RB_IP     = 4'd5,
      RB_IC     = 4'd6,
      RB_DIV    = 4'd7,
      RB_LCR    = 4'd8
   } rb_index_e;

   localparam int SRC_TXWM = 0;
   localparam int SRC_RXWM = 1;
   localparam int SRC_PERR = 3;
   localparam logic [3:0] SRC_MASK = 4'b1011;
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] count
);
   if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("uart_rb_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] store_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = store_q[rd_ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   store_q[e] <= '0;
         else if (do_push && wr_ptr_q == PTR_W'(e))    store_q[e] <= wdata;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R1
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> $stable(count)); // R4
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (count == '0)); // R3
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
   import uart_rb_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int THR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic [CNT_W-1:0] rx_cnt,
   input  logic [THR_W-1:0] tx_thr,
   input  logic [THR_W-1:0] rx_thr,
   input  logic             perr_evt,
   input  logic             ic_wr,
   input  logic [3:0]       ic_wdata,
   input  logic [3:0]       ie,
   output logic [3:0]       ip,
   output logic [3:0]       ic,
   output logic             irq
);
   if (THR_W >= CNT_W) begin : g_bad_thr
      $error("uart_rb_irq: threshold must be narrower than the count");
   end

   logic       perr_q;
   logic [3:0] ic_q;
   logic [3:0] armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ic_q   <= '0;
         perr_q <= 1'b0;
      end else begin
         ic_q <= ic_wr ? (ic_wdata & SRC_MASK) : '0;
         if (perr_evt)            perr_q <= 1'b1;
         else if (ic_q[SRC_PERR]) perr_q <= 1'b0;
      end
   end

   always_comb begin
      ip           = '0;
      ip[SRC_TXWM] = tx_cnt < CNT_W'(tx_thr);
      ip[SRC_RXWM] = rx_cnt > CNT_W'(rx_thr);
      ip[SRC_PERR] = perr_q;
   end
   assign ic = ic_q;

   for (genvar s = 0; s < 4; s++) begin : g_src
      assign armed[s] = ip[s] & ie[s];
   end
   assign irq = |armed;

   AST_IC_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_q != '0 && !ic_wr) |=> (ic_q == '0)); // R9
   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_q && !ic_q[SRC_PERR]) |=> perr_q); // R8
   AST_PERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_q[SRC_PERR] && !perr_evt) |=> !perr_q); // R9
   AST_PERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      perr_evt |=> perr_q); // R8
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int THR_W  = 3,
   parameter int DIV_W  = 16,
   parameter int ADDR_W = 6,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [7:0]        rx_data,
   input  logic              rx_valid,
   input  logic              rx_parity_err,
   output logic              cfg_tx_en,
   output logic              cfg_two_stop,
   output logic              cfg_rx_en,
   output logic [DIV_W-1:0]  cfg_divisor,
   output logic [2:0]        cfg_parity,
   output logic              irq
);
   if (ADDR_W < 6)    begin : g_bad_addr  $error("uart_regbank: ADDR_W too small");  end
   if (DIV_W > 32)    begin : g_bad_div   $error("uart_regbank: DIV_W too wide");    end
   if (THR_W > 8)     begin : g_bad_thr   $error("uart_regbank: THR_W too wide");    end

   localparam int THR_LSB = 16;

   logic [ADDR_W-3:0] word_idx;
   logic              rd_hit, wr_hit;
   logic              sel_tx, sel_rx, sel_txc, sel_rxc, sel_ie, sel_ic, sel_div, sel_lcr;

   assign word_idx = bus_addr[ADDR_W-1:2];
   assign rd_hit   = bus_valid && !bus_write;
   assign wr_hit   = bus_valid && bus_write;
   assign sel_tx   = word_idx == (ADDR_W-2)'(RB_TXDATA);
   assign sel_rx   = word_idx == (ADDR_W-2)'(RB_RXDATA);
   assign sel_txc  = word_idx == (ADDR_W-2)'(RB_TXCTRL);
   assign sel_rxc  = word_idx == (ADDR_W-2)'(RB_RXCTRL);
   assign sel_ie   = word_idx == (ADDR_W-2)'(RB_IE);
   assign sel_ic   = word_idx == (ADDR_W-2)'(RB_IC);
   assign sel_div  = word_idx == (ADDR_W-2)'(RB_DIV);
   assign sel_lcr  = word_idx == (ADDR_W-2)'(RB_LCR);

   // configuration registers
   logic             tx_en_q, two_stop_q, rx_en_q;
   logic [THR_W-1:0] tx_thr_q, rx_thr_q;
   logic [3:0]       ie_q;
   logic [DIV_W-1:0] div_q;
   logic [2:0]       par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q    <= 1'b0;
         two_stop_q <= 1'b0;
         rx_en_q    <= 1'b0;
         tx_thr_q   <= '0;
         rx_thr_q   <= '0;
         ie_q       <= '0;
         div_q      <= '0;
         par_q      <= '0;
      end else if (wr_hit) begin
         if (sel_txc) begin
            tx_en_q    <= bus_wdata[0];
            two_stop_q <= bus_wdata[1];
            tx_thr_q   <= bus_wdata[THR_LSB +: THR_W];
         end
         if (sel_rxc) begin
            rx_en_q  <= bus_wdata[0];
            rx_thr_q <= bus_wdata[THR_LSB +: THR_W];
         end
         if (sel_ie)  ie_q  <= bus_wdata[3:0] & SRC_MASK;
         if (sel_div) div_q <= bus_wdata[DIV_W-1:0];
         if (sel_lcr) par_q <= bus_wdata[5:3];
      end
   end

   // transmit queue
   logic             txq_full, txq_empty;
   logic [CNT_W-1:0] txq_cnt;

   uart_rb_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_hit && sel_tx),
      .wdata (bus_wdata[7:0]),
      .pop   (tx_valid && tx_ready),
      .rdata (tx_data),
      .full  (txq_full),
      .empty (txq_empty),
      .count (txq_cnt)
   );
   assign tx_valid = tx_en_q && !txq_empty;

   // receive queue
   logic             rxq_full, rxq_empty;
   logic [CNT_W-1:0] rxq_cnt;
   logic [7:0]       rxq_head;

   uart_rb_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid && rx_en_q),
      .wdata (rx_data),
      .pop   (rd_hit && sel_rx),
      .rdata (rxq_head),
      .full  (rxq_full),
      .empty (rxq_empty),
      .count (rxq_cnt)
   );

   // interrupts
   logic [3:0] ip_w, ic_w;

   uart_rb_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_cnt   (txq_cnt),
      .rx_cnt   (rxq_cnt),
      .tx_thr   (tx_thr_q),
      .rx_thr   (rx_thr_q),
      .perr_evt (rx_parity_err),
      .ic_wr    (wr_hit && sel_ic),
      .ic_wdata (bus_wdata[3:0]),
      .ie       (ie_q),
      .ip       (ip_w),
      .ic       (ic_w),
      .irq      (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (word_idx)
         (ADDR_W-2)'(RB_TXDATA): bus_rdata[31] = txq_full;
         (ADDR_W-2)'(RB_RXDATA): begin
            bus_rdata[31]  = rxq_empty;
            bus_rdata[7:0] = rxq_empty ? 8'h00 : rxq_head;
         end
         (ADDR_W-2)'(RB_TXCTRL): begin
            bus_rdata[0] = tx_en_q;
            bus_rdata[1] = two_stop_q;
            bus_rdata[THR_LSB +: THR_W] = tx_thr_q;
         end
         (ADDR_W-2)'(RB_RXCTRL): begin
            bus_rdata[0] = rx_en_q;
            bus_rdata[THR_LSB +: THR_W] = rx_thr_q;
         end
         (ADDR_W-2)'(RB_IE):  bus_rdata[3:0] = ie_q;
         (ADDR_W-2)'(RB_IP):  bus_rdata[3:0] = ip_w;
         (ADDR_W-2)'(RB_IC):  bus_rdata[3:0] = ic_w;
         (ADDR_W-2)'(RB_DIV): bus_rdata[DIV_W-1:0] = div_q;
         (ADDR_W-2)'(RB_LCR): bus_rdata[5:3] = par_q;
         default:             bus_rdata = '0;
      endcase
   end

   assign cfg_tx_en    = tx_en_q;
   assign cfg_two_stop = two_stop_q;
   assign cfg_rx_en    = rx_en_q;
   assign cfg_divisor  = div_q;
   assign cfg_parity   = par_q;

   AST_RX_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en_q && !(rd_hit && sel_rx)) |=> $stable(rxq_cnt)); // R4
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ready && !(wr_hit && sel_tx)) |=> $stable(txq_cnt)); // R1
endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0, rx_parity_err = 1'b0;
   logic        cfg_tx_en, cfg_two_stop, cfg_rx_en;
   logic [15:0] cfg_divisor;
   logic [2:0]  cfg_parity;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   uart_regbank i_uart_regbank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
      .cfg_tx_en(cfg_tx_en), .cfg_two_stop(cfg_two_stop), .cfg_rx_en(cfg_rx_en),
      .cfg_divisor(cfg_divisor), .cfg_parity(cfg_parity), .irq(irq)
   );

   localparam logic [5:0] A_TX = 6'h00, A_RX = 6'h04, A_TXC = 6'h08, A_RXC = 6'h0C,
                          A_IE = 6'h10, A_IP = 6'h14, A_IC = 6'h18, A_DIV = 6'h1C,
                          A_LCR = 6'h20;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   // samples in the access cycle; the pop (if any) lands at the next edge
   task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1ns d = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic expect_reg(input logic [5:0] a, input logic [31:0] exp, input string req);
      logic [31:0] v;
      bus_rd(a, v);
      check(v === exp, req, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state of every word and of irq
      expect_reg(A_TX, 32'h0, "R11 txdata reset");
      expect_reg(A_RX, 32'h8000_0000, "R11 rxdata reset");
      expect_reg(A_TXC, 32'h0, "R11 txctrl reset");
      expect_reg(A_RXC, 32'h0, "R11 rxctrl reset");
      expect_reg(A_IE, 32'h0, "R11 ie reset");
      expect_reg(A_IP, 32'h0, "R11 ip reset");
      expect_reg(A_IC, 32'h0, "R11 ic reset");
      expect_reg(A_DIV, 32'h0, "R11 div reset");
      expect_reg(A_LCR, 32'h0, "R11 lcr reset");
      check(irq === 1'b0, "R11 irq reset", {31'b0, irq}, 32'h0);

      // R5 R11 field masking and config outputs
      bus_wr(A_TXC, 32'hFFFF_FFFF);
      expect_reg(A_TXC, 32'h0007_0003, "R5 txctrl fields");
      check({cfg_tx_en, cfg_two_stop} === 2'b11, "R5 cfg tx", {30'b0, cfg_tx_en, cfg_two_stop}, 32'h3);
      bus_wr(A_RXC, 32'hFFFF_FFFF);
      expect_reg(A_RXC, 32'h0007_0001, "R5 rxctrl fields");
      check(cfg_rx_en === 1'b1, "R5 cfg rx", {31'b0, cfg_rx_en}, 32'h1);
      bus_wr(A_DIV, 32'hFFFF_A5C3);
      expect_reg(A_DIV, 32'h0000_A5C3, "R11 div field");
      check(cfg_divisor === 16'hA5C3, "R11 cfg divisor", {16'b0, cfg_divisor}, 32'hA5C3);
      bus_wr(A_LCR, 32'hFFFF_FFFF);
      expect_reg(A_LCR, 32'h0000_0038, "R11 lcr field");
      check(cfg_parity === 3'd7, "R11 cfg parity", {29'b0, cfg_parity}, 32'h7);
      bus_wr(A_IE, 32'hFFFF_FFFF);
      expect_reg(A_IE, 32'h0000_000B, "R8 ie mask");
      bus_wr(A_IE, 32'h0);
      bus_wr(A_RXC, 32'h0);

      // R1 R2 R6 transmit sweep: every threshold, every fill level
      for (int thr = 0; thr < 8; thr++) begin
         bus_wr(A_TXC, 32'(thr) << 16);
         for (int n = 0; n <= 8; n++) begin
            bus_rd(A_IP, v);
            check(v[0] === (n < thr), "R6 tx watermark", v, {31'b0, 1'(n < thr)});
            bus_rd(A_TX, v);
            check(v === (n == 8 ? 32'h8000_0000 : 32'h0), "R2 tx full flag", v,
                  (n == 8 ? 32'h8000_0000 : 32'h0));
            if (n < 8) bus_wr(A_TX, 32'hFFFF_FF00 | 32'(thr * 16 + n));
         end
         bus_wr(A_TX, 32'h0000_00EE);   // dropped: queue full
         check(tx_valid === 1'b0, "R1 no output while disabled", {31'b0, tx_valid}, 32'h0);
         bus_wr(A_TXC, (32'(thr) << 16) | 32'h1);
         @(negedge clk);
         tx_ready = 1'b1;
         for (int k = 0; k < 8; k++) begin
            #1ns;
            check(tx_valid === 1'b1 && tx_data === 8'(thr * 16 + k), "R1 tx order",
                  {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'(thr * 16 + k)});
            @(negedge clk);
         end
         #1ns;
         check(tx_valid === 1'b0, "R1 full write dropped", {31'b0, tx_valid}, 32'h0);
         tx_ready = 1'b0;
         bus_wr(A_TXC, 32'h0);
      end

      // R4 receive disabled drops
      rx_push(8'h5A);
      expect_reg(A_RX, 32'h8000_0000, "R4 rx disabled drop");

      // R3 R4 R7 receive sweep
      for (int thr = 0; thr < 8; thr++) begin
         bus_wr(A_RXC, (32'(thr) << 16) | 32'h1);
         for (int n = 0; n <= 8; n++) begin
            bus_rd(A_IP, v);
            check(v[1] === (n > thr), "R7 rx watermark", v, {30'b0, 1'(n > thr), 1'b0});
            if (n < 8) rx_push(8'(8'h80 + thr * 16 + n));
         end
         rx_push(8'h11);                 // dropped: queue full
         bus_wr(A_RX, 32'h0000_0077);    // ignored
         for (int k = 0; k < 8; k++) begin
            bus_rd(A_RX, v);
            check(v === {24'b0, 8'(8'h80 + thr * 16 + k)}, "R3 rx read order", v,
                  {24'b0, 8'(8'h80 + thr * 16 + k)});
         end
         bus_rd(A_RX, v);
         check(v === 32'h8000_0000, "R4 rx full drop / R3 empty", v, 32'h8000_0000);
         bus_rd(A_RX, v);
         check(v === 32'h8000_0000, "R3 empty read no effect", v, 32'h8000_0000);
      end
      bus_wr(A_RXC, 32'h0);

      // R8 sticky parity pending, IP write ignored, R10 irq
      @(negedge clk); rx_parity_err = 1'b1;
      @(negedge clk); rx_parity_err = 1'b0;
      repeat (3) @(negedge clk);
      expect_reg(A_IP, 32'h8, "R8 parity sticky");
      bus_wr(A_IP, 32'h0);
      expect_reg(A_IP, 32'h8, "R8 ip write ignored");
      check(irq === 1'b0, "R10 irq masked", {31'b0, irq}, 32'h0);
      bus_wr(A_IE, 32'h8);
      #1ns check(irq === 1'b1, "R10 irq enabled", {31'b0, irq}, 32'h1);

      // R9 plain clear: IC reads back for one cycle, then zero
      bus_wr(A_IC, 32'hFFFF_FFFF);
      #1ns;
      bus_valid = 1'b1; bus_addr = A_IC; #1ns v = bus_rdata; bus_valid = 1'b0;
      check(v === 32'hB, "R9 ic visible one cycle", v, 32'hB);
      @(negedge clk);
      expect_reg(A_IC, 32'h0, "R9 ic self clear");
      expect_reg(A_IP, 32'h0, "R9 parity cleared");
      check(irq === 1'b0, "R10 irq after clear", {31'b0, irq}, 32'h0);

      // R9 clear coinciding with a new parity pulse: set wins
      bus_wr(A_IC, 32'h8);
      rx_parity_err = 1'b1;
      @(negedge clk); rx_parity_err = 1'b0;
      expect_reg(A_IP, 32'h8, "R9 new error beats clear");
      expect_reg(A_IC, 32'h0, "R9 ic zero after race");
      bus_wr(A_IC, 32'h8);
      @(negedge clk);
      expect_reg(A_IP, 32'h0, "R9 second clear");

      // R10 R6 transmit watermark drives irq
      bus_wr(A_TXC, 32'h0003_0000);
      bus_wr(A_IE, 32'h1);
      #1ns check(irq === 1'b1, "R10 tx wm irq", {31'b0, irq}, 32'h1);
      bus_wr(A_IE, 32'h2);
      #1ns check(irq === 1'b0, "R10 rx wm disabled source", {31'b0, irq}, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule